// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Committed Updates

This block turns a free-running clock into a stream of single-cycle enable pulses at a programmable, possibly non-integer fraction of that clock. The divisor is held in a small register file. It is stored as an offset field that carries both integer and fractional bits. The divisor actually used is the field value plus one whole unit, so a field of zero divides by exactly 1.0.

Software writes a new field into a shadow copy. That copy has no effect until software sets a trigger bit. The hardware then loads the shadow divisor at the next output period boundary and clears the trigger bit on the same edge. A fixed integer pre-divider sits ahead of the fractional stage, so the fractional stage counts pre-divided ticks. A build-time option freezes the divisor: the field is then constant, and writes and triggers have no effect.

The fractional part is handled by an accumulator. At each period boundary it adds the fractional bits of the divisor. When that sum carries, the coming period is one tick longer, so the long-run average ratio equals the divisor exactly.

Top module: `frac_clk_div`

## Requirements
- R1: After reset, register word 0 reads `RST_FIELD << FIELD_LSB` with all other bits zero, register word 1 reads zero, and `en_o` stays low until the first period has elapsed.
- R2: The scaled divisor equals the field value plus 2^FRAC_W, counted in units of 1/2^FRAC_W tick. A field of 0 produces one pulse on every tick.
- R3: `en_o` is high for one cycle at the last tick of each period. A period lasts the integer part of the divisor in ticks, plus one tick when adding the fractional bits to a FRAC_W-bit accumulator at the period's start overflows. The accumulator starts at zero after reset. Any 2^FRAC_W consecutive periods therefore total exactly divisor × 2^FRAC_W / 2^FRAC_W ticks.
- R4: The all-ones field gives the largest divisor, (2^FIELD_W − 1 + 2^FRAC_W) / 2^FRAC_W. With the defaults, 16 consecutive periods then total 271 ticks.
- R5: A write to word 0 stores all 32 bits, and word 0 reads them back. Bits outside [FIELD_LSB +: FIELD_W] do not affect the output. The field goes only to the shadow copy, so the pulse spacing does not change until a trigger commits it.
- R6: Writing word 1 with bit 0 set makes bit 0 of word 1 read 1 from the next cycle on. That bit is cleared on the clock edge at the period boundary that loads the shadow divisor, and the new divisor governs the period that starts there. Writing word 1 with bit 0 clear has no effect.
- R7: A further trigger, or a further field write, made while a trigger is pending does not cause an extra commit. The single commit uses the newest shadow field.
- R8: The pre-divider produces one tick every PRE_DIV clocks, so the pulse spacing in clocks is the period in ticks times PRE_DIV.
- R9: With FIXED_DIV set, word 0 always reads `RST_FIELD << FIELD_LSB`, word 1 always reads zero, and writes change neither the readback nor the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write word select: 0 divisor word, 1 trigger word |
| wr_data | input | 32 | Write data |
| rd_addr | input | 1 | Read word select, same encoding as wr_addr |
| rd_data | output | 32 | Combinational read data |
| en_o | output | 1 | Divided clock-enable pulse |

## Verification
On every cycle the assertions check four things. The active divisor moves only at a period boundary. A pending trigger stays set until a boundary consumes it and then drops. Pulses are never further apart than the largest possible period. With a pre-divider, two pulses are never adjacent. The exact length of each period, the carry pattern of the fractional accumulator, and the rule that the newest shadow value wins among stacked triggers are shown only by the bench. Its behavioural model predicts every pulse and every readback, and targeted scenarios add gap and sum measurements.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int REG_W    = 32;
    localparam int TRIG_BIT = 0;

    typedef enum logic {
        SEL_DIVISOR = 1'b0,
        SEL_TRIGGER = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic            en;
        reg_sel_e        sel;
        logic [REG_W-1:0] data;
    } reg_wr_t;

    function automatic logic [REG_W-1:0] field_pick(
        input logic [REG_W-1:0] word,
        input int unsigned      lsb,
        input int unsigned      width
    );
        logic [REG_W-1:0] m;
        m = (REG_W'(1) << width) - REG_W'(1);
        return (word >> lsb) & m;
    endfunction

endpackage

// File: rtl/frac_div_regs.sv
module frac_div_regs
    import frac_div_pkg::*;
#(
    parameter int FIELD_W   = 8,
    parameter int FIELD_LSB = 8,
    parameter int RST_FIELD = 32,
    parameter bit FIXED_DIV = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            wr,
    input  reg_sel_e           rd_sel,
    input  logic               commit,
    output logic [REG_W-1:0]   rd_data,
    output logic [FIELD_W-1:0] shadow_field,
    output logic               pending
);

    localparam logic [REG_W-1:0] RST_WORD = REG_W'(RST_FIELD) << FIELD_LSB;

    logic [REG_W-1:0] word_q;
    logic             pend_q;

    generate
        if (FIXED_DIV) begin : g_fixed
            assign word_q = RST_WORD;
            assign pend_q = 1'b0;
        end else begin : g_prog
            logic trig_set;
            assign trig_set = wr.en && (wr.sel == SEL_TRIGGER) && wr.data[TRIG_BIT];

            always_ff @(posedge clk) begin
                if (rst) begin
                    word_q <= RST_WORD;
                    pend_q <= 1'b0;
                end else begin
                    if (wr.en && (wr.sel == SEL_DIVISOR))
                        word_q <= wr.data;
                    pend_q <= (pend_q && !commit) || trig_set;
                end
            end
        end
    endgenerate

    assign shadow_field = FIELD_W'(field_pick(word_q, FIELD_LSB, FIELD_W));
    assign pending      = pend_q;

    always_comb begin
        if (rd_sel == SEL_TRIGGER) begin
            rd_data           = '0;
            rd_data[TRIG_BIT] = pend_q;
        end else begin
            rd_data = word_q;
        end
    end

endmodule

// File: rtl/frac_div_prescale.sv
module frac_div_prescale #(
    parameter int PRE_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    generate
        if (PRE_DIV <= 1) begin : g_bypass
            assign tick = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(PRE_DIV);
            localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (cnt_q == LAST)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + CW'(1);
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/frac_div_core.sv
module frac_div_core #(
    parameter int FIELD_W   = 8,
    parameter int FRAC_W    = 4,
    parameter int RST_FIELD = 32,
    localparam int SCALED_W = FIELD_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                pending,
    input  logic [FIELD_W-1:0]  shadow_field,
    output logic                boundary,
    output logic [SCALED_W-1:0] act_scaled
);

    localparam int INT_W = SCALED_W - FRAC_W;
    localparam int LEN_W = INT_W + 1;
    localparam logic [SCALED_W-1:0] ONE = SCALED_W'(1) << FRAC_W;
    localparam logic [SCALED_W-1:0] RST_SCALED = SCALED_W'(RST_FIELD) + ONE;

    logic [SCALED_W-1:0] act_q;
    logic [FRAC_W-1:0]   acc_q;
    logic [LEN_W-1:0]    len_q;
    logic [LEN_W-1:0]    cnt_q;

    logic [SCALED_W-1:0] next_div;
    logic [FRAC_W:0]     frac_sum;
    logic [LEN_W-1:0]    next_len;

    assign boundary = tick && (cnt_q == len_q - LEN_W'(1));

    always_comb begin
        next_div = pending ? ({1'b0, shadow_field} + ONE) : act_q;
        frac_sum = {1'b0, acc_q} + {1'b0, next_div[FRAC_W-1:0]};
        next_len = LEN_W'(next_div[SCALED_W-1:FRAC_W]) + LEN_W'(frac_sum[FRAC_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= RST_SCALED;
            acc_q <= '0;
            len_q <= LEN_W'(RST_SCALED[SCALED_W-1:FRAC_W]);
            cnt_q <= '0;
        end else if (tick) begin
            if (boundary) begin
                act_q <= next_div;
                acc_q <= frac_sum[FRAC_W-1:0];
                len_q <= next_len;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    assign act_scaled = act_q;

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import frac_div_pkg::*;
#(
    parameter int FIELD_W   = 8,
    parameter int FRAC_W    = 4,
    parameter int FIELD_LSB = 8,
    parameter int RST_FIELD = 32,
    parameter int PRE_DIV   = 2,
    parameter bit FIXED_DIV = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_addr,
    input  logic [31:0] wr_data,
    input  logic        rd_addr,
    output logic [31:0] rd_data,
    output logic        en_o
);

    localparam int SCALED_W = FIELD_W + 1;

    reg_wr_t             wr_bus;
    logic                src_tick;
    logic                period_end;
    logic                trig_pend;
    logic [FIELD_W-1:0]  shadow_field;
    logic [SCALED_W-1:0] act_scaled;

    assign wr_bus = '{en: wr_en, sel: reg_sel_e'(wr_addr), data: wr_data};

    frac_div_regs #(
        .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB),
        .RST_FIELD(RST_FIELD), .FIXED_DIV(FIXED_DIV)
    ) u_regs (
        .clk(clk), .rst(rst), .wr(wr_bus), .rd_sel(reg_sel_e'(rd_addr)),
        .commit(period_end), .rd_data(rd_data),
        .shadow_field(shadow_field), .pending(trig_pend)
    );

    frac_div_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst(rst), .tick(src_tick)
    );

    frac_div_core #(
        .FIELD_W(FIELD_W), .FRAC_W(FRAC_W), .RST_FIELD(RST_FIELD)
    ) u_core (
        .clk(clk), .rst(rst), .tick(src_tick), .pending(trig_pend),
        .shadow_field(shadow_field), .boundary(period_end),
        .act_scaled(act_scaled)
    );

    assign en_o = period_end;

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
    parameter int FIELD_W = 8,
    parameter int FRAC_W  = 4,
    parameter int PRE_DIV = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               en_o,
    input logic               pend,
    input logic               wr_en,
    input logic               wr_addr,
    input logic [31:0]        wr_data,
    input logic [FIELD_W:0]   act_scaled
);

    localparam int MAX_TICKS = ((2 ** FIELD_W - 1 + 2 ** FRAC_W) >> FRAC_W) + 1;
    localparam int MAX_GAP   = MAX_TICKS * (PRE_DIV < 1 ? 1 : PRE_DIV);

    logic trig_wr;
    int   gap_q;

    assign trig_wr = wr_en && wr_addr && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst || en_o) gap_q <= 0;
        else             gap_q <= gap_q + 1;
    end

    a_r5_active_holds: assert property (@(posedge clk) disable iff (rst)
        !en_o |=> $stable(act_scaled));

    a_r6_pending_holds: assert property (@(posedge clk) disable iff (rst)
        (pend && !en_o) |=> pend);

    a_r6_pending_clears: assert property (@(posedge clk) disable iff (rst)
        (pend && en_o && !trig_wr) |=> !pend);

    a_r4_gap_bound: assert property (@(posedge clk) disable iff (rst)
        gap_q < MAX_GAP);

    a_r8_no_adjacent: assert property (@(posedge clk) disable iff (rst)
        (PRE_DIV > 1 && en_o) |=> !en_o);

endmodule

bind frac_clk_div frac_clk_div_chk #(
    .FIELD_W(FIELD_W), .FRAC_W(FRAC_W), .PRE_DIV(PRE_DIV)
) u_chk (
    .clk(clk), .rst(rst), .en_o(en_o), .pend(trig_pend),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .act_scaled(act_scaled)
);

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;

    localparam int PRE = 2;
    localparam int LSB = 8;
    localparam int RSTF = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data, rd_fix;
    logic        en_o, en_fix;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frac_clk_div i_frac_clk_div (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .en_o(en_o)
    );

    frac_clk_div #(.RST_FIELD(16), .PRE_DIV(1), .FIXED_DIV(1'b1)) i_fixed (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_fix), .en_o(en_fix)
    );

    // behavioural reference model
    int m_pc, m_mc, m_len, m_acc, m_act, m_shad, m_pend, m_nd, m_s;
    logic [31:0] m_word;

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0; m_mc = 0; m_act = RSTF + 16; m_len = m_act / 16;
            m_acc = 0; m_shad = RSTF; m_pend = 0; m_word = 32'(RSTF) << LSB;
        end else begin
            automatic bit tk = (m_pc == PRE - 1);
            automatic bit bd = tk && (m_mc == m_len - 1);
            m_pc = tk ? 0 : m_pc + 1;
            if (tk) m_mc = bd ? 0 : m_mc + 1;
            if (bd) begin
                m_nd = m_pend ? m_shad + 16 : m_act;
                m_act = m_nd;
                m_s = m_acc + (m_nd % 16);
                m_len = m_nd / 16 + (m_s >= 16 ? 1 : 0);
                m_acc = m_s % 16;
                m_pend = 0;
            end
            if (wr_en && !wr_addr) begin
                m_word = wr_data;
                m_shad = int'((wr_data >> LSB) & 32'hFF);
            end
            if (wr_en && wr_addr && wr_data[0]) m_pend = 1;
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison, sampled well after the active edge
    always @(posedge clk) begin
        #4;
        if (!rst) begin
            check("R3 pulse", en_o, (m_pc == PRE - 1) && (m_mc == m_len - 1));
            if (rd_addr) check("R6 trigger readback", rd_data, m_pend);
            else         check("R5 word readback", rd_data, m_word);
        end
    end

    task automatic write(input logic a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic next_en(output int t);
        t = 0;
        do begin @(posedge clk); #4; t++; end while (!en_o && t < 2000);
    endtask

    task automatic gaps(input int n, output int total);
        int t;
        total = 0;
        next_en(t);
        for (int i = 0; i < n; i++) begin next_en(t); total += t; end
    endtask

    task automatic wait_clear();
        rd_addr = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #4;
            if (rd_data[0] == 1'b0) break;
        end
    endtask

    int g;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd_addr = 1'b0; #1; check("R1 word0", rd_data, 32'h0000_2000);
        rd_addr = 1'b1; #1; check("R1 word1", rd_data, 0);
        check("R1 en low", en_o, 0);
        rd_addr = 1'b0;

        // R3 default integer ratio 3.0 with pre-divide 2 -> 6 clocks
        gaps(1, g); check("R3 default gap", g, 6);

        // R5 shadow only, whole word stored
        write(1'b0, 32'hA5C3_085A);
        #1; check("R5 readback", rd_data, 32'hA5C3_085A);
        gaps(2, g); check("R5 unchanged until trigger", g, 12);

        // R6 trigger handshake, ratio 1.5
        write(1'b1, 32'h1);
        rd_addr = 1'b1; #1; check("R6 pending set", rd_data, 1);
        wait_clear(); check("R6 pending cleared", rd_data, 0);
        rd_addr = 1'b0;
        gaps(4, g); check("R3 fractional sum", g, 12);

        // R6 writing zero to trigger has no effect
        write(1'b1, 32'h0);
        rd_addr = 1'b1; #1; check("R6 zero write ignored", rd_data, 0);
        rd_addr = 1'b0;

        // R2 / R8 field zero -> one pulse per tick -> PRE clocks
        write(1'b0, 32'h0000_0000);
        write(1'b1, 32'h1);
        wait_clear(); rd_addr = 1'b0;
        gaps(1, g); check("R2 field zero gap", g, PRE);
        gaps(1, g); check("R8 pre-divided spacing", g, PRE);

        // R4 maximum divisor: 16 periods = 271 ticks
        write(1'b0, 32'h0000_FF00);
        write(1'b1, 32'h1);
        wait_clear(); rd_addr = 1'b0;
        gaps(16, g); check("R4 max divisor sum", g, 271 * PRE);

        // R7 stacked triggers: newest shadow (4.0) wins, single commit
        write(1'b0, 32'h0000_7000);
        write(1'b1, 32'h1);
        write(1'b0, 32'h0000_3000);
        write(1'b1, 32'h1);
        wait_clear(); rd_addr = 1'b0;
        gaps(1, g); check("R7 newest shadow gap", g, 4 * PRE);
        rd_addr = 1'b1; #1; check("R7 no second commit pending", rd_data, 0);
        rd_addr = 1'b0;

        // R9 fixed variant ignores writes
        write(1'b0, 32'hFFFF_FFFF);
        write(1'b1, 32'h1);
        #1; check("R9 fixed word0", rd_fix, 32'h0000_1000);
        rd_addr = 1'b1; #1; check("R9 fixed word1", rd_fix, 0);
        rd_addr = 1'b0;
        begin
            int cnt = 0;
            for (int i = 0; i < 40; i++) begin
                @(posedge clk); #4;
                if (en_fix) cnt++;
            end
            check("R9 fixed spacing", cnt, 20);
        end

        repeat (5) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule